// File: doc/BRIEF.md
# JTAG Debug-Port Scan Register Model

This block is the target-side data-register set that sits behind a JTAG TAP controller. The TAP supplies the current 4-bit instruction and one-cycle strobes for Capture-DR, Shift-DR and Update-DR. The block picks the selected scan chain and shifts it least-significant bit first from `tdi` to `tdo`. The chains are the 32-bit identification register, the 1-bit bypass register, the 35-bit debug-port and access-port access registers, and the 35-bit abort register.

An access scan carries a read-not-write flag, two address bits and a 32-bit data word. At Update-DR the block either serves a debug-port register at once or launches one request to a back-end access port, which answers after a variable number of cycles.

Each Capture-DR on an access chain decides between two outcomes:

- If the previous access-port request is still outstanding, the chain loads WAIT, and the following update is discarded.
- Otherwise the chain loads OK together with the pending read result.

An optional overrun mode turns every WAIT into a sticky error. While that error is set, later access-port requests are dropped until an abort write clears it.

Two state machines carry the behaviour:

- The scan gate has the states `SC_CLOSED`, `SC_OK` and `SC_WAIT`.
  - Capture on an access chain moves it to `SC_OK` when the back end is idle and to `SC_WAIT` when it is busy.
  - Capture on any other chain, and every update, return it to `SC_CLOSED`.
  - An update is acted on only from `SC_OK`.
- The access-port tracker has the states `AP_IDLE`, `AP_PEND_RD` and `AP_PEND_WR`.
  - An accepted access-port update moves it from `AP_IDLE` to the pending state that matches the flag.
  - A response from the back end returns it to `AP_IDLE`.

Top module: `jdp_scan_regs`

## Requirements
- R1: After reset no request is issued, `tdo` is 0, a 32-bit scan with instruction 4'b1110 returns the `IDCODE_VAL` parameter, and both control/status flags read as 0.
- R2: Instruction codes are abort 4'b1000, debug-port access 4'b1010, access-port access 4'b1011, identification 4'b1110 and bypass 4'b1111. Any other code selects the 1-bit bypass chain, which captures 0 and delays `tdi` by one shift.
- R3: An access scan is 35 bits shifted LSB first. In the shifted-in value, bit 0 is read-not-write (1 = read), bits 2:1 are address bits A[3:2] and bits 34:3 are data. In the value shifted out, bits 2:0 are the acknowledge (3'b010 = OK, 3'b001 = WAIT) and bits 34:3 are data.
- R4: An accepted access-port update drives `ap_req_valid` high for exactly the cycle after the update strobe. With it, `ap_req_write` is the inverse of the flag, `ap_req_addr` is {SELECT access-port bank, A[3:2]} and `ap_req_wdata` is the scanned data.
- R5: A read result (a debug-port read at update, or an access-port read at its response) is returned as data with OK by the next access scan.
- R6: A Capture-DR on an access chain while an access-port request is outstanding loads WAIT. The following Update-DR then issues no request and discards the shifted-in value.
- R7: The OK/WAIT decision is fixed at Capture-DR. A response that arrives during the shift does not make that update act.
- R8: A debug-port read at address 4'hC returns the pending result and leaves it unchanged, so repeated reads return the same value.
- R9: A debug-port write at address 4'h8 sets SELECT. Bits 3:0 of SELECT choose what address 4'h4 shows: bank 0 is control/status and bank 1 is the `TARGET_VAL` parameter. Bits 7:4 of SELECT hold the access-port bank.
- R10: In control/status, bit 0 is the overrun-detect enable (writable, 0 after reset) and bit 1 is the sticky overrun flag. A WAIT capture sets the flag only while the enable is 1.
- R11: While the sticky flag is set, an access-port scan captures OK when the back end is idle and its update issues no request.
- R12: An update of the abort chain with data bit 4 set clears the sticky flag, after which access-port requests are issued again.
- R13: At most one access-port request is outstanding, and `ap_req_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| instr | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe, one bit per cycle |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected chain |
| ap_req_valid | output | 1 | One-cycle access-port request pulse |
| ap_req_write | output | 1 | Request is a write |
| ap_req_addr | output | APBANK_W+2 | Access-port bank and register address |
| ap_req_wdata | output | 32 | Write data |
| ap_rsp_valid | input | 1 | Back-end completion of the outstanding request |
| ap_rsp_rdata | input | 32 | Read data that goes with the completion |

## Verification
The embedded assertions check on every cycle the properties that hold cycle by cycle:

- requests appear only one cycle after an update and as single pulses, with none while one is outstanding;
- an update after a WAIT capture, or while the sticky flag is set, never produces a request;
- the sticky flag stays set until an abort and rises only with detection enabled;
- the bypass chain captures 0.

The scan format, acknowledge encodings, read-buffer results, bank selection and the race in which a response lands during the shift can only be shown by the bench's full scans. The bench compares every shifted-out word and counts the requests the back end receives.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
    localparam int SCAN_W = 35;
    localparam int DATA_W = 32;
    localparam int ACK_W  = 3;

    localparam logic [3:0] IR_ABORT  = 4'b1000;
    localparam logic [3:0] IR_DPACC  = 4'b1010;
    localparam logic [3:0] IR_APACC  = 4'b1011;
    localparam logic [3:0] IR_IDCODE = 4'b1110;
    localparam logic [3:0] IR_BYPASS = 4'b1111;

    localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

    typedef enum logic [2:0] {
        SEL_BYPASS,
        SEL_IDCODE,
        SEL_DPACC,
        SEL_APACC,
        SEL_ABORT
    } chain_sel_e;

    typedef enum logic [1:0] {
        SC_CLOSED,
        SC_OK,
        SC_WAIT
    } scan_gate_e;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_PEND_RD,
        AP_PEND_WR
    } ap_state_e;
endpackage

// File: rtl/jdp_instr_decode.sv
module jdp_instr_decode
    import jdp_pkg::*;
(
    input  logic [3:0] instr,
    output chain_sel_e sel
);
    always_comb begin
        unique case (instr)
            IR_ABORT:  sel = SEL_ABORT;
            IR_DPACC:  sel = SEL_DPACC;
            IR_APACC:  sel = SEL_APACC;
            IR_IDCODE: sel = SEL_IDCODE;
            default:   sel = SEL_BYPASS;   // R2: unknown codes fall back to bypass
        endcase
    end
endmodule

// File: rtl/jdp_shift_chain.sv
module jdp_shift_chain
    import jdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chain_sel_e        sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [SCAN_W-1:0] cap_val,
    output logic [SCAN_W-1:0] chain_q,
    output logic              tdo
);
    localparam int PAD_W = SCAN_W - DATA_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (capture) begin
            chain_q <= cap_val;
        end else if (shift) begin
            unique case (sel)
                SEL_BYPASS: chain_q <= {{(SCAN_W-1){1'b0}}, tdi};
                SEL_IDCODE: chain_q <= {{PAD_W{1'b0}}, tdi, chain_q[DATA_W-1:1]};
                default:    chain_q <= {tdi, chain_q[SCAN_W-1:1]};
            endcase
        end
    end

    assign tdo = chain_q[0];

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && sel == SEL_BYPASS) |=> (chain_q[0] == 1'b0)); // R2
endmodule

// File: rtl/jdp_access_ctrl.sv
module jdp_access_ctrl
    import jdp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h1A5C_3E01,
    parameter logic [31:0] TARGET_VAL = 32'h0C0F_FEE1,
    parameter int          DPBANK_W   = 4,
    parameter int          APBANK_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  chain_sel_e            sel,
    input  logic                  capture,
    input  logic                  update,
    input  logic [SCAN_W-1:0]     chain_q,
    output logic [SCAN_W-1:0]     cap_val,
    output logic                  ap_req_valid,
    output logic                  ap_req_write,
    output logic [APBANK_W+1:0]   ap_req_addr,
    output logic [DATA_W-1:0]     ap_req_wdata,
    input  logic                  ap_rsp_valid,
    input  logic [DATA_W-1:0]     ap_rsp_rdata
);
    localparam int SEL_W     = DPBANK_W + APBANK_W;
    localparam int ABORT_BIT = 4;

    scan_gate_e gate_q, gate_d;
    ap_state_e  ap_q, ap_d;

    logic              detect_q;
    logic              sticky_q;
    logic [SEL_W-1:0]  select_q;
    logic [DATA_W-1:0] rdbuf_q;

    logic              rnw;
    logic [1:0]        addr;
    logic [DATA_W-1:0] data;
    logic              busy;
    logic              access_sel;
    logic              accept;
    logic              ap_fire;
    logic [DPBANK_W-1:0] dp_bank;

    assign rnw        = chain_q[0];
    assign addr       = chain_q[2:1];
    assign data       = chain_q[SCAN_W-1:ACK_W];
    assign busy       = (ap_q != AP_IDLE);
    assign access_sel = (sel == SEL_DPACC) || (sel == SEL_APACC);
    assign accept     = update && (gate_q == SC_OK);
    assign ap_fire    = accept && (sel == SEL_APACC) && !sticky_q;
    assign dp_bank    = select_q[DPBANK_W-1:0];

    // next-state logic for both machines
    always_comb begin
        gate_d = gate_q;
        if (capture) begin
            if (access_sel) gate_d = busy ? SC_WAIT : SC_OK;
            else            gate_d = SC_CLOSED;
        end else if (update) begin
            gate_d = SC_CLOSED;
        end

        ap_d = ap_q;
        unique case (ap_q)
            AP_IDLE:    if (ap_fire) ap_d = rnw ? AP_PEND_RD : AP_PEND_WR;
            AP_PEND_RD: if (ap_rsp_valid) ap_d = AP_IDLE;
            AP_PEND_WR: if (ap_rsp_valid) ap_d = AP_IDLE;
            default:    ap_d = AP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= SC_CLOSED;
            ap_q   <= AP_IDLE;
        end else begin
            gate_q <= gate_d;
            ap_q   <= ap_d;
        end
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            detect_q     <= 1'b0;
            sticky_q     <= 1'b0;
            select_q     <= '0;
            rdbuf_q      <= '0;
            ap_req_valid <= 1'b0;
            ap_req_write <= 1'b0;
            ap_req_addr  <= '0;
            ap_req_wdata <= '0;
        end else begin
            ap_req_valid <= ap_fire;
            if (ap_fire) begin
                ap_req_write <= !rnw;
                ap_req_addr  <= {select_q[SEL_W-1:DPBANK_W], addr};
                ap_req_wdata <= data;
            end

            if (capture && access_sel && busy && detect_q) begin
                sticky_q <= 1'b1;
            end else if (update && sel == SEL_ABORT && data[ABORT_BIT]) begin
                sticky_q <= 1'b0;
            end

            if (ap_q == AP_PEND_RD && ap_rsp_valid) begin
                rdbuf_q <= ap_rsp_rdata;
            end else if (accept && sel == SEL_DPACC) begin
                if (rnw) begin
                    unique case (addr)
                        2'd0: rdbuf_q <= '0;
                        2'd1: begin
                            if (dp_bank == '0)
                                rdbuf_q <= {{(DATA_W-2){1'b0}}, sticky_q, detect_q};
                            else if (dp_bank == DPBANK_W'(1))
                                rdbuf_q <= TARGET_VAL;
                            else
                                rdbuf_q <= '0;
                        end
                        2'd2: rdbuf_q <= '0;
                        2'd3: rdbuf_q <= rdbuf_q;
                        default: rdbuf_q <= rdbuf_q;
                    endcase
                end else begin
                    if (addr == 2'd1 && dp_bank == '0) detect_q <= data[0];
                    if (addr == 2'd2)                  select_q <= data[SEL_W-1:0];
                end
            end
        end
    end

    // value loaded into the selected chain at Capture-DR
    always_comb begin
        unique case (sel)
            SEL_BYPASS: cap_val = '0;
            SEL_IDCODE: cap_val = {{(SCAN_W-DATA_W){1'b0}}, IDCODE_VAL};
            default:    cap_val = busy ? {{DATA_W{1'b0}}, ACK_WAIT}
                                       : {rdbuf_q, ACK_OK};
        endcase
    end

    AST_REQ_FOLLOWS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |-> $past(update)); // R4
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |=> !ap_req_valid); // R13
    AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_q != AP_IDLE && !ap_rsp_valid) |=> !ap_req_valid); // R13
    AST_WAIT_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (update && gate_q == SC_WAIT) |=> !ap_req_valid); // R6
    AST_STICKY_BLOCKS_AP: assert property (@(posedge clk) disable iff (!rst_n)
        (update && sticky_q) |=> !ap_req_valid); // R11
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !(update && sel == SEL_ABORT)) |=> sticky_q); // R10
    AST_STICKY_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_q && !detect_q) |=> !sticky_q); // R10
endmodule

// File: rtl/jdp_scan_regs.sv
module jdp_scan_regs
    import jdp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h1A5C_3E01,
    parameter logic [31:0] TARGET_VAL = 32'h0C0F_FEE1,
    parameter int          DPBANK_W   = 4,
    parameter int          APBANK_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          instr,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    output logic                tdo,
    output logic                ap_req_valid,
    output logic                ap_req_write,
    output logic [APBANK_W+1:0] ap_req_addr,
    output logic [31:0]         ap_req_wdata,
    input  logic                ap_rsp_valid,
    input  logic [31:0]         ap_rsp_rdata
);
    chain_sel_e        sel;
    logic [SCAN_W-1:0] chain_q;
    logic [SCAN_W-1:0] cap_val;

    jdp_instr_decode u_decode (
        .instr (instr),
        .sel   (sel)
    );

    jdp_shift_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .cap_val (cap_val),
        .chain_q (chain_q),
        .tdo     (tdo)
    );

    jdp_access_ctrl #(
        .IDCODE_VAL (IDCODE_VAL),
        .TARGET_VAL (TARGET_VAL),
        .DPBANK_W   (DPBANK_W),
        .APBANK_W   (APBANK_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .capture      (capture_dr),
        .update       (update_dr),
        .chain_q      (chain_q),
        .cap_val      (cap_val),
        .ap_req_valid (ap_req_valid),
        .ap_req_write (ap_req_write),
        .ap_req_addr  (ap_req_addr),
        .ap_req_wdata (ap_req_wdata),
        .ap_rsp_valid (ap_rsp_valid),
        .ap_rsp_rdata (ap_rsp_rdata)
    );
endmodule

// File: tb/test_jdp_scan_regs.sv
`timescale 1ns/1ps
module test_jdp_scan_regs;
    import jdp_pkg::*;

    localparam logic [31:0] IDV = 32'h1A5C_3E01;
    localparam logic [31:0] TGV = 32'h0C0F_FEE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  instr = IR_IDCODE;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        ap_req_valid, ap_req_write;
    logic [5:0]  ap_req_addr;
    logic [31:0] ap_req_wdata;
    logic        ap_rsp_valid = 1'b0;
    logic [31:0] ap_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    jdp_scan_regs #(.IDCODE_VAL(IDV), .TARGET_VAL(TGV)) i_jdp_scan_regs (
        .clk(clk), .rst_n(rst_n), .instr(instr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .ap_req_valid(ap_req_valid), .ap_req_write(ap_req_write),
        .ap_req_addr(ap_req_addr), .ap_req_wdata(ap_req_wdata),
        .ap_rsp_valid(ap_rsp_valid), .ap_rsp_rdata(ap_rsp_rdata)
    );

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    int rsp_lat = 2;
    logic [31:0] mem [64];

    function automatic logic [34:0] acc(input logic [1:0] a, input logic rd, input logic [31:0] d);
        return {d, a, rd};
    endfunction

    typedef struct packed {
        logic [34:0] din;
        logic [34:0] exp;
    } vec_t;

    // debug-port scans with instruction 4'b1010; each expects the previous result
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{acc(2'd1, 1'b1, 32'h0), {32'h0, ACK_OK}},  // R1 read ctrl/stat
        '{acc(2'd3, 1'b1, 32'h0), {32'h0, ACK_OK}},  // R1 flags reset to 0
        '{acc(2'd2, 1'b0, 32'h1), {32'h0, ACK_OK}},  // R9 select bank 1
        '{acc(2'd1, 1'b1, 32'h0), {32'h0, ACK_OK}},  // R9
        '{acc(2'd3, 1'b1, 32'h0), {TGV,   ACK_OK}},  // R9 bank 1 value
        '{acc(2'd3, 1'b1, 32'h0), {TGV,   ACK_OK}},  // R8 no side effect
        '{acc(2'd2, 1'b0, 32'h0), {TGV,   ACK_OK}},  // R9 back to bank 0
        '{acc(2'd1, 1'b0, 32'h1), {TGV,   ACK_OK}},  // R10 enable detect
        '{acc(2'd1, 1'b1, 32'h0), {TGV,   ACK_OK}},  // R5
        '{acc(2'd3, 1'b1, 32'h0), {32'h1, ACK_OK}},  // R10 enable reads 1
        '{acc(2'd1, 1'b0, 32'h0), {32'h1, ACK_OK}},  // R3 write format
        '{acc(2'd1, 1'b1, 32'h0), {32'h1, ACK_OK}},  // R5
        '{acc(2'd3, 1'b1, 32'h0), {32'h0, ACK_OK}}   // R10 enable cleared
    };

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [3:0] ir, input int len, input logic [34:0] din,
                        output logic [34:0] dout);
        dout = '0;
        @(negedge clk);
        instr = ir;
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        shift_dr = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    // back-end access port with programmable latency
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (ap_req_valid) begin
                logic        wr;
                logic [5:0]  ad;
                wr = ap_req_write;
                ad = ap_req_addr;
                req_cnt++;
                if (wr) mem[ad] = ap_req_wdata;
                repeat (rsp_lat) @(negedge clk);
                ap_rsp_rdata = wr ? 32'h0 : mem[ad];
                ap_rsp_valid = 1'b1;
                @(negedge clk);
                ap_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [34:0] d;
        int c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 req idle", {34'b0, ap_req_valid}, 35'd0);
        check("R1 tdo", {34'b0, tdo}, 35'd0);
        rst_n = 1'b1;
        @(negedge clk);
        scan(IR_IDCODE, 32, '0, d);
        check("R1 idcode", d, {3'b0, IDV});

        // vector table
        for (int i = 0; i < NV; i++) begin
            scan(IR_DPACC, 35, VECS[i].din, d);
            total++;
            if (d !== VECS[i].exp) begin
                bad++;
                $display("FAIL R3 vec %0d act=%h exp=%h", i, d, VECS[i].exp);
            end
        end

        // R2 bypass: unknown code and explicit code
        scan(4'b0011, 4, 35'b1101, d);
        check("R2 unknown bypass", d, 35'b1010);
        scan(IR_BYPASS, 4, 35'b1101, d);
        check("R2 bypass", d, 35'b1010);

        // R4 access-port write request
        scan(IR_DPACC, 35, acc(2'd2, 1'b0, 32'h30), d);
        scan(IR_APACC, 35, acc(2'd1, 1'b0, 32'hDEAD_BEEF), d);
        check("R4 request", {ap_req_valid, ap_req_write, ap_req_addr, ap_req_wdata[26:0]},
              {1'b1, 1'b1, 6'h0D, 27'h6AD_BEEF});
        check("R4 wdata", {3'b0, ap_req_wdata}, {3'b0, 32'hDEAD_BEEF});
        repeat (5) @(negedge clk);

        // R5 access-port read then result in next scan
        scan(IR_APACC, 35, acc(2'd1, 1'b1, 32'h0), d);
        check("R5 read ack", {32'b0, d[2:0]}, {32'b0, ACK_OK});
        repeat (6) @(negedge clk);
        scan(IR_DPACC, 35, acc(2'd3, 1'b1, 32'h0), d);
        check("R5 read data", d, {32'hDEAD_BEEF, ACK_OK});

        // R6 WAIT while pending discards the update
        rsp_lat = 60;
        c0 = req_cnt;
        scan(IR_APACC, 35, acc(2'd0, 1'b0, 32'h1111), d);
        scan(IR_APACC, 35, acc(2'd2, 1'b0, 32'h2222), d);
        check("R6 wait ack", {32'b0, d[2:0]}, {32'b0, ACK_WAIT});
        repeat (80) @(negedge clk);
        check("R6 one request", 35'(req_cnt - c0), 35'd1);
        check("R6 discarded data", {3'b0, mem[14]}, 35'd0);
        scan(IR_DPACC, 35, acc(2'd1, 1'b1, 32'h0), d);
        scan(IR_DPACC, 35, acc(2'd3, 1'b1, 32'h0), d);
        check("R10 no sticky when disabled", d, {32'h0, ACK_OK});

        // R7 response lands during the shift
        rsp_lat = 10;
        c0 = req_cnt;
        scan(IR_APACC, 35, acc(2'd0, 1'b0, 32'h3333), d);
        scan(IR_APACC, 35, acc(2'd2, 1'b0, 32'h4444), d);
        check("R7 wait ack", {32'b0, d[2:0]}, {32'b0, ACK_WAIT});
        repeat (30) @(negedge clk);
        check("R7 no late request", 35'(req_cnt - c0), 35'd1);
        scan(IR_DPACC, 35, acc(2'd3, 1'b1, 32'h0), d);
        check("R7 ok after response", {32'b0, d[2:0]}, {32'b0, ACK_OK});

        // R10 sticky overrun with detection enabled
        scan(IR_DPACC, 35, acc(2'd1, 1'b0, 32'h1), d);
        rsp_lat = 60;
        scan(IR_APACC, 35, acc(2'd0, 1'b0, 32'h5), d);
        scan(IR_APACC, 35, acc(2'd0, 1'b0, 32'h6), d);
        check("R10 wait ack", {32'b0, d[2:0]}, {32'b0, ACK_WAIT});
        repeat (80) @(negedge clk);
        scan(IR_DPACC, 35, acc(2'd1, 1'b1, 32'h0), d);
        scan(IR_DPACC, 35, acc(2'd3, 1'b1, 32'h0), d);
        check("R10 sticky set", d, {32'h3, ACK_OK});

        // R11 access-port scans dropped while sticky
        c0 = req_cnt;
        scan(IR_APACC, 35, acc(2'd2, 1'b0, 32'h7777), d);
        check("R11 ok not wait", {32'b0, d[2:0]}, {32'b0, ACK_OK});
        repeat (20) @(negedge clk);
        check("R11 no request", 35'(req_cnt - c0), 35'd0);

        // R12 abort clears sticky
        scan(IR_ABORT, 35, {32'h10, 3'b000}, d);
        scan(IR_DPACC, 35, acc(2'd1, 1'b1, 32'h0), d);
        scan(IR_DPACC, 35, acc(2'd3, 1'b1, 32'h0), d);
        check("R12 sticky cleared", d, {32'h1, ACK_OK});
        rsp_lat = 2;
        scan(IR_APACC, 35, acc(2'd2, 1'b0, 32'h8888), d);
        check("R12 request resumes", {34'b0, ap_req_valid}, 35'd1);
        repeat (10) @(negedge clk);
        check("R13 idle after response", {34'b0, ap_req_valid}, 35'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule